// File: doc/BRIEF.md
# Time-Shared FM Cross-Product Discriminator

This block turns a stream of complex baseband samples into the two raw terms an FM demodulator needs. Eight channels share one clock domain and one set of multipliers. Each input sample arrives with a channel tag. The block forms the cross-product of the current sample with the previous sample of the same channel, which approximates I·dQ − Q·dI using a one-sample difference. It also forms the instantaneous power of the current sample. A divider further downstream turns the pair into a frequency estimate.

Each channel gets a new sample at a low rate compared with the fabric clock, so one datapath serves all channels in turn. A small store indexed by the channel tag keeps the last I and Q of every channel. Results leave a fixed number of cycles after their input, carry the same tag, and keep the input order. Sums that fall outside the output width clamp to the nearest extreme instead of wrapping.

Top module: `fm_xprod_disc`

## Requirements
- R1: For a valid sample (I, Q) on channel c whose stored previous sample is (Ip, Qp), the numerator output equals Ip·Q − I·Qp as a signed two's-complement value.
- R2: The denominator output for that sample equals I·I + Q·Q as an unsigned value, using only the current sample.
- R3: Each channel keeps its own previous sample. Samples on other channels in between do not change what a channel uses as its previous sample.
- R4: After reset, every channel's stored previous sample is zero, so the first numerator of each channel is zero.
- R5: Two valid samples on the same channel in consecutive cycles are handled correctly: the second one uses the first one as its previous sample.
- R6: `out_valid` rises exactly LAT = 2 + OUT_REG clock edges after the edge that captured `in_valid`. `out_chan` carries the input's tag, and results leave in input order.
- R7: When the exact numerator is above or below the OW-bit signed range, it clamps to 2^(OW-1)−1 or −2^(OW-1). A denominator above 2^OW−1 clamps to 2^OW−1.
- R8: Out of reset, `out_valid`, `out_num`, `out_den` and `out_chan` are zero. While `out_valid` is low, the data outputs keep their last value.
- R9: A cycle with `in_valid` low leaves every channel's stored previous sample unchanged, whatever is on `in_i`, `in_q` and `in_chan` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 3 | Channel tag of the input sample |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| out_valid | output | 1 | Result strobe |
| out_chan | output | 3 | Channel tag of the result |
| out_num | output | 32 | Cross-product numerator, signed, saturated |
| out_den | output | 32 | Power denominator, unsigned, saturated |

## Verification
The hardest case to reach from the ports is clamping. With 16-bit inputs and a 32-bit output, the exact numerator never leaves the signed range. A second instance is therefore built with a 24-bit output and no extra output register. A channel on that instance is driven with full-scale samples that are a quarter turn apart, in both rotation directions, so both clamp limits are reached. The bench also sends back-to-back samples on one channel, to check that each write to the history store is visible to the next read. It sends idle cycles with garbage on the data inputs to check that the store is left alone.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

   typedef enum logic [0:0] {
      SAT_SIGNED   = 1'b0,
      SAT_UNSIGNED = 1'b1
   } sat_kind_e;

   localparam int unsigned N_PROD = 4;

endpackage

// File: rtl/fmd_chan_hist.sv
module fmd_chan_hist #(
   parameter int unsigned N_CH = 8,
   parameter int unsigned SW   = 16,
   localparam int unsigned CW  = $clog2(N_CH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CW-1:0]        rd_ch,
   output logic signed [SW-1:0] rd_i,
   output logic signed [SW-1:0] rd_q,
   input  logic                 wr_en,
   input  logic [CW-1:0]        wr_ch,
   input  logic signed [SW-1:0] wr_i,
   input  logic signed [SW-1:0] wr_q
);

   logic signed [SW-1:0] mem_i [N_CH];
   logic signed [SW-1:0] mem_q [N_CH];

   for (genvar e = 0; e < N_CH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mem_i[e] <= '0;
            mem_q[e] <= '0;
         end else if (wr_en && (wr_ch == CW'(e))) begin
            mem_i[e] <= wr_i;
            mem_q[e] <= wr_q;
         end
      end
   end

   assign rd_i = mem_i[rd_ch];
   assign rd_q = mem_q[rd_ch];

   AST_WB_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(rst_n) && (rd_ch == $past(wr_ch)))
         |-> (rd_i == $past(wr_i) && rd_q == $past(wr_q))); // R5

endmodule

// File: rtl/fmd_mul.sv
module fmd_mul #(
   parameter int unsigned W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic signed [W-1:0]    a,
   input  logic signed [W-1:0]    b,
   output logic signed [2*W-1:0]  p
);

   always_ff @(posedge clk) begin
      if (!rst_n)  p <= '0;
      else if (en) p <= a * b;
   end

endmodule

// File: rtl/fmd_sat.sv
module fmd_sat #(
   parameter int unsigned        IW   = 33,
   parameter int unsigned        OW   = 32,
   parameter fmd_pkg::sat_kind_e KIND = fmd_pkg::SAT_SIGNED
) (
   input  logic [IW-1:0] din,
   output logic [OW-1:0] dout
);

   if (KIND == fmd_pkg::SAT_SIGNED) begin : g_signed
      if (OW >= IW) begin : g_wide
         assign dout = OW'($signed(din));
      end else begin : g_clamp
         localparam logic [IW-1:0] HI = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
         localparam logic [IW-1:0] LO = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};
         always_comb begin
            if ($signed(din) > $signed(HI))      dout = {1'b0, {(OW-1){1'b1}}};
            else if ($signed(din) < $signed(LO)) dout = {1'b1, {(OW-1){1'b0}}};
            else                                 dout = din[OW-1:0];
         end
      end
   end else begin : g_unsigned
      if (OW >= IW) begin : g_wide
         assign dout = OW'(din);
      end else begin : g_clamp
         assign dout = (|din[IW-1:OW]) ? {OW{1'b1}} : din[OW-1:0];
      end
   end

endmodule

// File: rtl/fm_xprod_disc.sv
module fm_xprod_disc #(
   parameter int unsigned N_CH    = 8,
   parameter int unsigned SW      = 16,
   parameter int unsigned OW      = 32,
   parameter int unsigned OUT_REG = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [$clog2(N_CH)-1:0]     in_chan,
   input  logic signed [SW-1:0]        in_i,
   input  logic signed [SW-1:0]        in_q,
   output logic                        out_valid,
   output logic [$clog2(N_CH)-1:0]     out_chan,
   output logic signed [OW-1:0]        out_num,
   output logic [OW-1:0]               out_den
);
   import fmd_pkg::*;

   localparam int unsigned CW  = $clog2(N_CH);
   localparam int unsigned PW  = 2 * SW;
   localparam int unsigned XW  = PW + 1;
   localparam int unsigned LAT = 2 + OUT_REG;
   localparam int unsigned KW  = $clog2(LAT + 1);

   if (N_CH < 2 || N_CH != (1 << CW)) begin : g_chk_ch
      $error("N_CH must be a power of two, at least 2");
   end
   if (SW < 2) begin : g_chk_sw
      $error("SW too small");
   end
   if (OW < 2) begin : g_chk_ow
      $error("OW too small");
   end
   if (OUT_REG > 1) begin : g_chk_or
      $error("OUT_REG must be 0 or 1");
   end

   // previous-sample store
   logic signed [SW-1:0] prev_i, prev_q;

   fmd_chan_hist #(.N_CH(N_CH), .SW(SW)) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_ch (in_chan),
      .rd_i  (prev_i),
      .rd_q  (prev_q),
      .wr_en (in_valid),
      .wr_ch (in_chan),
      .wr_i  (in_i),
      .wr_q  (in_q)
   );

   // shared multipliers: cross terms then squares
   logic signed [SW-1:0] op_a [N_PROD];
   logic signed [SW-1:0] op_b [N_PROD];
   logic signed [PW-1:0] prod [N_PROD];

   assign op_a[0] = prev_i;  assign op_b[0] = in_q;
   assign op_a[1] = in_i;    assign op_b[1] = prev_q;
   assign op_a[2] = in_i;    assign op_b[2] = in_i;
   assign op_a[3] = in_q;    assign op_b[3] = in_q;

   for (genvar g = 0; g < N_PROD; g++) begin : g_mul
      fmd_mul #(.W(SW)) u_mul (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (in_valid),
         .a     (op_a[g]),
         .b     (op_b[g]),
         .p     (prod[g])
      );
   end

   logic          s1_v;
   logic [CW-1:0] s1_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v <= 1'b0;
         s1_c <= '0;
      end else begin
         s1_v <= in_valid;
         if (in_valid) s1_c <= in_chan;
      end
   end

   // exact sums, one bit wider than a product
   logic signed [XW-1:0] num_x;
   logic [XW-1:0]        den_x;
   logic [OW-1:0]        num_s, den_s;

   assign num_x = $signed({prod[0][PW-1], prod[0]}) - $signed({prod[1][PW-1], prod[1]});
   assign den_x = {1'b0, prod[2]} + {1'b0, prod[3]};

   fmd_sat #(.IW(XW), .OW(OW), .KIND(SAT_SIGNED)) u_sat_num (
      .din  (num_x),
      .dout (num_s)
   );

   fmd_sat #(.IW(XW), .OW(OW), .KIND(SAT_UNSIGNED)) u_sat_den (
      .din  (den_x),
      .dout (den_s)
   );

   // optional retiming stage between the saturation logic and the outputs
   logic          fin_v;
   logic [CW-1:0] fin_c;
   logic [OW-1:0] fin_num, fin_den;

   if (OUT_REG == 1) begin : g_retime
      logic          s2_v;
      logic [CW-1:0] s2_c;
      logic [OW-1:0] s2_num, s2_den;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s2_v   <= 1'b0;
            s2_c   <= '0;
            s2_num <= '0;
            s2_den <= '0;
         end else begin
            s2_v <= s1_v;
            if (s1_v) begin
               s2_c   <= s1_c;
               s2_num <= num_s;
               s2_den <= den_s;
            end
         end
      end
      assign fin_v   = s2_v;
      assign fin_c   = s2_c;
      assign fin_num = s2_num;
      assign fin_den = s2_den;
   end else begin : g_direct
      assign fin_v   = s1_v;
      assign fin_c   = s1_c;
      assign fin_num = num_s;
      assign fin_den = den_s;
   end

   // output register, loads only on a result
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_chan  <= '0;
         out_num   <= '0;
         out_den   <= '0;
      end else begin
         out_valid <= fin_v;
         if (fin_v) begin
            out_chan <= fin_c;
            out_num  <= $signed(fin_num);
            out_den  <= fin_den;
         end
      end
   end

   // edges since reset, saturating at LAT, for the alignment checks
   logic [KW-1:0] warm_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                   warm_cnt <= '0;
      else if (warm_cnt != KW'(LAT)) warm_cnt <= warm_cnt + 1'b1;
   end

   AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_cnt == KW'(LAT)) |-> (out_valid == $past(in_valid, LAT))); // R6

   AST_TAG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      ((warm_cnt == KW'(LAT)) && out_valid) |-> (out_chan == $past(in_chan, LAT))); // R6

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_num) && $stable(out_den) && $stable(out_chan))); // R8

   AST_SAT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_v && (num_x != '0)) |-> (num_s[OW-1] == num_x[XW-1])); // R7

endmodule

// File: tb/sim_fm_xprod_disc.sv
module sim_fm_xprod_disc;

   localparam int NCH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [2:0] in_chan = '0;
   logic signed [15:0] in_i = '0, in_q = '0;

   logic        v0, v1;
   logic [2:0]  c0, c1;
   logic signed [31:0] n0;
   logic [31:0] d0;
   logic signed [23:0] n1;
   logic [23:0] d1;

   always #2 clk = ~clk;

   fm_xprod_disc u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
      .in_i(in_i), .in_q(in_q), .out_valid(v0), .out_chan(c0),
      .out_num(n0), .out_den(d0));

   fm_xprod_disc #(.OW(24), .OUT_REG(0)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
      .in_i(in_i), .in_q(in_q), .out_valid(v1), .out_chan(c1),
      .out_num(n1), .out_den(d1));

   typedef struct {
      int     ch;
      longint num;
      longint den;
      int     iss;
      string  req;
   } item_t;

   item_t sb0[$];
   item_t sb1[$];
   int checks = 0, fails = 0, cyc = 0;
   int prv_i [NCH];
   int prv_q [NCH];
   bit fresh [NCH];
   bit done = 0;
   logic signed [31:0] last_n0;
   logic [31:0] last_d0;
   logic [2:0]  last_c0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic longint clamp_s(longint v, int ow);
      longint hi = (longint'(1) <<< (ow - 1)) - 1;
      longint lo = -(longint'(1) <<< (ow - 1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   function automatic longint clamp_u(longint v, int ow);
      longint hi = (longint'(1) <<< ow) - 1;
      return (v > hi) ? hi : v;
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: one valid sample, expected results pushed to both scoreboards
   task automatic send(int ch, int i, int q, string req);
      item_t it;
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_chan  = 3'(ch);
      in_i     = 16'(i);
      in_q     = 16'(q);
      it.ch  = ch;
      it.num = longint'(prv_i[ch]) * q - longint'(i) * prv_q[ch];
      it.den = longint'(i) * i + longint'(q) * q;
      it.iss = cyc;
      it.req = fresh[ch] ? {req, " R4"} : req;
      sb0.push_back(it);
      sb1.push_back(it);
      prv_i[ch] = i;
      prv_q[ch] = q;
      fresh[ch] = 1'b0;
   endtask

   // idle cycles with garbage on the data inputs (R9)
   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         in_valid = 1'b0;
         in_chan  = 3'($urandom);
         in_i     = 16'($urandom);
         in_q     = 16'($urandom);
      end
   endtask

   // monitor for both instances
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (v0) begin
            if (sb0.size() == 0) chk(1'b0, "R6", "u0 unexpected result", 1, 0);
            else begin
               item_t e;
               e = sb0.pop_front();
               chk(c0 == 3'(e.ch), {e.req, " R6"}, "u0 chan", c0, e.ch);
               chk(cyc - e.iss == 3, "R6", "u0 latency", cyc - e.iss, 3);
               chk(longint'(n0) == clamp_s(e.num, 32), {e.req, " R1"}, "u0 num", n0, clamp_s(e.num, 32));
               chk(longint'(d0) == clamp_u(e.den, 32), {e.req, " R2"}, "u0 den", d0, clamp_u(e.den, 32));
            end
         end else begin
            chk(n0 == last_n0 && d0 == last_d0 && c0 == last_c0, "R8", "u0 hold num", n0, last_n0);
         end
         last_n0 = n0; last_d0 = d0; last_c0 = c0;
         if (v1) begin
            if (sb1.size() == 0) chk(1'b0, "R6", "u1 unexpected result", 1, 0);
            else begin
               item_t e;
               e = sb1.pop_front();
               chk(c1 == 3'(e.ch), {e.req, " R6"}, "u1 chan", c1, e.ch);
               chk(cyc - e.iss == 2, "R6", "u1 latency", cyc - e.iss, 2);
               chk(longint'(n1) == clamp_s(e.num, 24), {e.req, " R7"}, "u1 num", n1, clamp_s(e.num, 24));
               chk(longint'(d1) == clamp_u(e.den, 24), {e.req, " R7"}, "u1 den", d1, clamp_u(e.den, 24));
            end
         end
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1;
         fails++; checks++;
         $display("FAIL watchdog expired, queues %0d %0d expected 0", sb0.size(), sb1.size());
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin
         prv_i[c] = 0; prv_q[c] = 0; fresh[c] = 1'b1;
      end
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(v0 == 0 && n0 == 0 && d0 == 0 && c0 == 0, "R8", "u0 reset outputs", n0, 0);
      chk(v1 == 0 && n1 == 0 && d1 == 0, "R8", "u1 reset outputs", n1, 0);
      last_n0 = n0; last_d0 = d0; last_c0 = c0;

      // round-robin over all channels, random samples (R1 R2 R3)
      for (int r = 0; r < 6; r++)
         for (int c = 0; c < NCH; c++)
            send(c, int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R3");
      idle(5);

      // same channel back to back (R5)
      for (int k = 0; k < 10; k++)
         send(3, int'($signed(16'($urandom))), int'($signed(16'($urandom))), "R5");

      // garbage between samples of one channel (R9)
      send(2, 100, 200, "R9");
      idle(4);
      send(2, -300, 50, "R9");
      idle(3);
      send(2, 7, -9, "R9");

      // full-scale extremes (R1 R2)
      send(6, -32768, -32768, "R1");
      send(6, -32768, 32767, "R1");
      send(6, 32767, -32768, "R2");
      send(6, -32768, -32768, "R2");

      // quarter turns at full scale; clamp on the 24-bit instance (R7)
      send(5, 32767, 0, "R7");
      send(5, 0, 32767, "R7");
      send(5, 32767, 0, "R7");
      send(5, 0, -32767, "R7");

      // mixed random interleave with gaps (R3 R6)
      for (int k = 0; k < 40; k++) begin
         send(int'($urandom_range(7, 0)), int'($signed(16'($urandom))),
              int'($signed(16'($urandom))), "R3");
         if (k % 5 == 0) idle(2);
      end
      idle(10);

      chk(sb0.size() == 0, "R6", "u0 results outstanding", sb0.size(), 0);
      chk(sb1.size() == 0, "R6", "u1 results outstanding", sb1.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule